// File: doc/BRIEF.md
# Pin-Scanning Interrupt Dispatcher

The dispatcher watches a bank of interrupt input pins and decides which of them hold a request. A pin in level mode is pending for as long as its active level is present. A pin in edge mode becomes pending on an inactive-to-active transition and stays pending until it has been dispatched. Either kind of pin can also take a one-cycle pulse request. For a level pin, a pulse makes the pin pending for exactly one service pass.

A service pass walks the pins from the lowest index to the highest. At each pin it reads that pin's 64-bit redirection entry through a table read port. Every pending pin whose entry is not masked produces one message on a valid/ready output. The message carries the destination, destination mode, delivery mode, vector, polarity and trigger mode from that entry.

A pass starts on any new request, or when the register block signals that the table was written. Only one pass runs at a time. A start that arrives during a pass is held and runs as a further pass once the current one ends. The per-pin trigger mode and active-low setting come from the register block as flat vectors. These vectors must agree with the trigger field of each entry.

Top module: `irq_pin_dispatcher`

## Requirements
- R1: Each message takes its fields from the visited pin's entry. The vector is bits 7:0, the delivery mode bits 10:8, the destination mode bit 11, the polarity bit 13, the trigger mode bit 15 and the destination bits 63:56. The message also reports the pin index. Bit 16 set means the pin is masked.
- R2: A pin in level mode (`level_mode_i` bit = 1) is pending while its active level is present. Removing the level clears the pin, so a later pass sends nothing for it.
- R3: A pin in edge mode becomes pending on an inactive-to-active transition. An active-to-inactive transition neither sets the pin nor starts a pass.
- R4: A one-cycle `pulse_i` on a level-mode pin makes it pending for one visit. The pin is cleared once it has been visited, so a later pass sends nothing for it.
- R5: A pass visits pins in ascending index order. It sends exactly one message for each pending, unmasked pin.
- R6: A pin that is pending but masked is skipped. It stays pending and is dispatched by a pass that runs after it has been unmasked.
- R7: Dispatching an edge-mode pin clears it. A level-mode pin whose level is still present is dispatched again by every later pass.
- R8: A new request or a `tbl_wr_i` pulse starts a pass. Only one pass runs at a time. A start seen during a pass triggers exactly one further pass after the current pass finishes.
- R9: An entry with delivery mode 7 is sent with vector 0xFF and `msg_unsup_o` = 1. For other delivery modes `msg_unsup_o` is 0.
- R10: While `msg_valid_o` is high and `msg_ready_i` is low, the dispatcher stalls. It holds valid and every message field unchanged.
- R11: A pin with `active_low_i` set is inverted before level or edge detection. For such a pin a high-to-low transition is the request edge.
- R12: After reset no message is valid and the table read index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Raw interrupt pin levels |
| pulse_i | input | NUM_PINS | One-cycle pulse requests |
| level_mode_i | input | NUM_PINS | Per-pin trigger mode, 1 = level |
| active_low_i | input | NUM_PINS | Per-pin inversion, 1 = active low |
| tbl_wr_i | input | 1 | Redirection table was written; request a pass |
| tbl_idx_o | output | PIN_W | Index of the entry being read |
| tbl_entry_i | input | 64 | Entry at `tbl_idx_o`, combinational read |
| msg_ready_i | input | 1 | Consumer accepts the message |
| msg_valid_o | output | 1 | Message valid |
| msg_pin_o | output | PIN_W | Source pin of the message |
| msg_dest_o | output | 8 | Destination |
| msg_dest_mode_o | output | 1 | Destination mode |
| msg_dlv_mode_o | output | 3 | Delivery mode |
| msg_vector_o | output | 8 | Vector, 0xFF for delivery mode 7 |
| msg_polarity_o | output | 1 | Polarity field |
| msg_trigger_o | output | 1 | Trigger mode field |
| msg_unsup_o | output | 1 | Unsupported delivery mode flag |

## Verification
The hardest case to reach is a request that lands while a pass is already past that pin's index. The request must be carried into a second pass, and neither lost nor sent out of order. The bench raises an edge pin with a high index, waits until the scan has moved beyond a lower pin, and then raises that lower pin. The scoreboard then expects the higher pin first. A similar case is a masked pin that must survive a full pass while pending. The bench leaves it pending behind its mask, unmasks it, and pulses the table-write input to show that the pin is dispatched only then.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;
  localparam int ENTRY_W   = 64;
  localparam int VEC_LSB   = 0;
  localparam int DLV_LSB   = 8;
  localparam int DMODE_BIT = 11;
  localparam int POL_BIT   = 13;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 56;
  localparam logic [2:0] DLV_EXT = 3'd7;
  localparam logic [7:0] VEC_UNSUP = 8'hFF;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_mode;
    logic [2:0] dlv_mode;
    logic [7:0] vector;
    logic       polarity;
    logic       trigger;
    logic       unsup;
  } msg_t;

  function automatic msg_t decode_entry(input logic [ENTRY_W-1:0] e);
    msg_t m;
    m.dest      = e[DEST_LSB +: 8];
    m.dest_mode = e[DMODE_BIT];
    m.dlv_mode  = e[DLV_LSB +: 3];
    m.polarity  = e[POL_BIT];
    m.trigger   = e[TRIG_BIT];
    m.unsup     = (e[DLV_LSB +: 3] == DLV_EXT);
    m.vector    = m.unsup ? VEC_UNSUP : e[VEC_LSB +: 8];
    return m;
  endfunction
endpackage

// File: rtl/irq_pin_latch.sv
module irq_pin_latch #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pulse_i,
  input  logic [NUM_PINS-1:0] level_mode_i,
  input  logic [NUM_PINS-1:0] active_low_i,
  input  logic [NUM_PINS-1:0] visit_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] pend_o,
  output logic                req_o
);
  logic [NUM_PINS-1:0] new_req;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    logic lvl_q, prev_q, edge_q, hold_q, rise;
    assign rise = lvl_q & ~prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q  <= 1'b0;
        prev_q <= 1'b0;
        edge_q <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        lvl_q  <= pin_i[k] ^ active_low_i[k];
        prev_q <= lvl_q;
        // edge latch: a fresh request wins over a same-cycle dispatch clear
        if (level_mode_i[k])          edge_q <= 1'b0;
        else if (rise || pulse_i[k])  edge_q <= 1'b1;
        else if (clr_i[k])            edge_q <= 1'b0;
        // pulse hold for level pins lives until the pin is visited
        if (!level_mode_i[k])         hold_q <= 1'b0;
        else if (pulse_i[k])          hold_q <= 1'b1;
        else if (visit_i[k])          hold_q <= 1'b0;
      end
    end

    assign pend_o[k]  = level_mode_i[k] ? (lvl_q | hold_q) : edge_q;
    assign new_req[k] = rise | pulse_i[k];
  end

  assign req_o = |new_req;
endmodule

// File: rtl/irq_scan_ctrl.sv
module irq_scan_ctrl #(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [NUM_PINS-1:0] pend_i,
  input  logic                masked_i,
  input  logic                done_i,
  output logic [PIN_W-1:0]    idx_o,
  output logic [NUM_PINS-1:0] visit_o,
  output logic [NUM_PINS-1:0] clr_o,
  output logic                load_o,
  output logic                busy_o
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_SEND} st_t;
  localparam logic [PIN_W-1:0] LAST_IDX = PIN_W'(NUM_PINS - 1);

  st_t              st_q, st_d;
  logic [PIN_W-1:0] idx_q, idx_d;
  logic             again_q, again_d;
  logic             hit, last, step;
  logic [NUM_PINS-1:0] cur_oh;

  assign cur_oh  = NUM_PINS'(1) << idx_q;
  assign hit     = pend_i[idx_q] & ~masked_i;
  assign last    = (idx_q == LAST_IDX);
  assign step    = ((st_q == S_SCAN) && !hit) || ((st_q == S_SEND) && done_i);
  assign load_o  = (st_q == S_SCAN) && hit;
  assign visit_o = (st_q == S_SCAN) ? cur_oh : '0;
  assign clr_o   = load_o ? cur_oh : '0;
  assign busy_o  = (st_q != S_IDLE);
  assign idx_o   = idx_q;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    again_d = again_q;
    if (st_q == S_IDLE) begin
      again_d = 1'b0;
      if (start_i) begin
        st_d  = S_SCAN;
        idx_d = '0;
      end
    end else begin
      if (start_i) again_d = 1'b1;
      if (load_o) begin
        st_d = S_SEND;
      end else if (step) begin
        if (!last) begin
          st_d  = S_SCAN;
          idx_d = idx_q + 1'b1;
        end else begin
          idx_d   = '0;
          again_d = 1'b0;
          st_d    = (again_q || start_i) ? S_SCAN : S_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      again_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      again_q <= again_d;
    end
  end
endmodule

// File: rtl/irq_msg_reg.sv
module irq_msg_reg
  import irq_disp_pkg::*;
#(
  parameter int PIN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  msg_t             msg_i,
  input  logic [PIN_W-1:0] pin_i,
  input  logic             ready_i,
  output logic             valid_o,
  output msg_t             msg_o,
  output logic [PIN_W-1:0] pin_o,
  output logic             done_o
);
  assign done_o = valid_o & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      msg_o   <= '0;
      pin_o   <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      msg_o   <= msg_i;
      pin_o   <= pin_i;
    end else if (done_o) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_pin_dispatcher.sv
module irq_pin_dispatcher
  import irq_disp_pkg::*;
#(
  parameter int  NUM_PINS = 24,
  localparam int PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pulse_i,
  input  logic [NUM_PINS-1:0] level_mode_i,
  input  logic [NUM_PINS-1:0] active_low_i,
  input  logic                tbl_wr_i,
  output logic [PIN_W-1:0]    tbl_idx_o,
  input  logic [ENTRY_W-1:0]  tbl_entry_i,
  input  logic                msg_ready_i,
  output logic                msg_valid_o,
  output logic [PIN_W-1:0]    msg_pin_o,
  output logic [7:0]          msg_dest_o,
  output logic                msg_dest_mode_o,
  output logic [2:0]          msg_dlv_mode_o,
  output logic [7:0]          msg_vector_o,
  output logic                msg_polarity_o,
  output logic                msg_trigger_o,
  output logic                msg_unsup_o
);
  logic [NUM_PINS-1:0] pend, visit, clr;
  logic req, load, done, scan_busy;
  msg_t cur_msg, out_msg;

  irq_pin_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk_i, .rst_ni, .pin_i, .pulse_i, .level_mode_i, .active_low_i,
    .visit_i(visit), .clr_i(clr), .pend_o(pend), .req_o(req)
  );

  irq_scan_ctrl #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_scan (
    .clk_i, .rst_ni,
    .start_i(req | tbl_wr_i),
    .pend_i(pend),
    .masked_i(tbl_entry_i[MASK_BIT]),
    .done_i(done),
    .idx_o(tbl_idx_o),
    .visit_o(visit),
    .clr_o(clr),
    .load_o(load),
    .busy_o(scan_busy)
  );

  assign cur_msg = decode_entry(tbl_entry_i);

  irq_msg_reg #(.PIN_W(PIN_W)) u_msg (
    .clk_i, .rst_ni,
    .load_i(load), .msg_i(cur_msg), .pin_i(tbl_idx_o),
    .ready_i(msg_ready_i), .valid_o(msg_valid_o),
    .msg_o(out_msg), .pin_o(msg_pin_o), .done_o(done)
  );

  assign msg_dest_o      = out_msg.dest;
  assign msg_dest_mode_o = out_msg.dest_mode;
  assign msg_dlv_mode_o  = out_msg.dlv_mode;
  assign msg_vector_o    = out_msg.vector;
  assign msg_polarity_o  = out_msg.polarity;
  assign msg_trigger_o   = out_msg.trigger;
  assign msg_unsup_o     = out_msg.unsup;
endmodule

// File: rtl/irq_pin_dispatcher_chk.sv
module irq_pin_dispatcher_chk #(
  parameter int PIN_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scan_busy,
  input logic [PIN_W-1:0] tbl_idx_o,
  input logic             msg_ready_i,
  input logic             msg_valid_o,
  input logic [PIN_W-1:0] msg_pin_o,
  input logic [7:0]       msg_dest_o,
  input logic             msg_dest_mode_o,
  input logic [2:0]       msg_dlv_mode_o,
  input logic [7:0]       msg_vector_o,
  input logic             msg_polarity_o,
  input logic             msg_trigger_o,
  input logic             msg_unsup_o
);
  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o &&
      $stable({msg_pin_o, msg_dest_o, msg_dest_mode_o, msg_dlv_mode_o,
               msg_vector_o, msg_polarity_o, msg_trigger_o, msg_unsup_o}));

  // R9
  unsup_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && (msg_dlv_mode_o == 3'd7) |-> (msg_vector_o == 8'hFF) && msg_unsup_o);

  // R9
  sup_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && (msg_dlv_mode_o != 3'd7) |-> !msg_unsup_o);

  // R8
  scan_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_busy && $past(scan_busy) && (tbl_idx_o != $past(tbl_idx_o)) |->
      (tbl_idx_o == PIN_W'($past(tbl_idx_o) + 1'b1)) || (tbl_idx_o == '0));

  // R12
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !msg_valid_o && (tbl_idx_o == '0));
endmodule

bind irq_pin_dispatcher irq_pin_dispatcher_chk #(.PIN_W(PIN_W)) u_chk (
  .clk_i, .rst_ni, .scan_busy, .tbl_idx_o, .msg_ready_i, .msg_valid_o,
  .msg_pin_o, .msg_dest_o, .msg_dest_mode_o, .msg_dlv_mode_o, .msg_vector_o,
  .msg_polarity_o, .msg_trigger_o, .msg_unsup_o
);

// File: tb/irq_pin_dispatcher_tb_top.sv
module irq_pin_dispatcher_tb_top;
  localparam int N  = 24;
  localparam int PW = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] pin_i = '0, pulse_i = '0, level_mode_i = '0, active_low_i = '0;
  logic tbl_wr_i = 1'b0;
  logic msg_ready_i = 1'b1;
  logic [PW-1:0] tbl_idx_o, msg_pin_o;
  logic [63:0] tbl_entry_i;
  logic msg_valid_o, msg_dest_mode_o, msg_polarity_o, msg_trigger_o, msg_unsup_o;
  logic [7:0] msg_dest_o, msg_vector_o;
  logic [2:0] msg_dlv_mode_o;

  logic [63:0] tbl [N];
  assign tbl_entry_i = tbl[tbl_idx_o];

  always #2 clk_i = ~clk_i;

  irq_pin_dispatcher dut_i (
    .clk_i, .rst_ni, .pin_i, .pulse_i, .level_mode_i, .active_low_i, .tbl_wr_i,
    .tbl_idx_o, .tbl_entry_i, .msg_ready_i, .msg_valid_o, .msg_pin_o,
    .msg_dest_o, .msg_dest_mode_o, .msg_dlv_mode_o, .msg_vector_o,
    .msg_polarity_o, .msg_trigger_o, .msg_unsup_o
  );

  int checks = 0;
  int fails  = 0;
  logic [27:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [63:0] mk(input logic [7:0] dest, input logic dm,
      input logic [2:0] dlv, input logic [7:0] vec, input logic pol,
      input logic trig, input logic msk);
    return {dest, 39'b0, msk, trig, 1'b0, pol, 1'b0, dm, dlv, vec};
  endfunction

  function automatic logic [27:0] pack_exp(input logic [4:0] pin, input logic [63:0] e);
    logic un;
    un = (e[10:8] == 3'd7);
    return {pin, e[63:56], e[11], e[10:8], un ? 8'hFF : e[7:0], e[13], e[15], un};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic expect_msg(input int pin, input string tag);
    exp_q.push_back(pack_exp(5'(pin), tbl[pin]));
    tag_q.push_back(tag);
  endtask

  task automatic drain(input string tag);
    tick(80);
    check(exp_q.size() == 0, tag, "messages outstanding", 64'(exp_q.size()), 64'd0);
  endtask

  task automatic tbl_write_pulse();
    tbl_wr_i = 1'b1;
    tick(1);
    tbl_wr_i = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && msg_valid_o && msg_ready_i) begin
      logic [27:0] act;
      act = {msg_pin_o, msg_dest_o, msg_dest_mode_o, msg_dlv_mode_o, msg_vector_o,
             msg_polarity_o, msg_trigger_o, msg_unsup_o};
      if (exp_q.size() == 0) begin
        check(1'b0, "R5/R7", "unexpected message", 64'(act), 64'd0);
      end else begin
        logic [27:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(act == e, t, "message", 64'(act), 64'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) tbl[k] = mk(8'h0, 1'b0, 3'd0, 8'h20, 1'b0, 1'b0, 1'b1);
    active_low_i[12] = 1'b1;
    pin_i[12] = 1'b1;
    tick(5);
    rst_ni = 1'b1;
    tick(2);
    // R12
    check(msg_valid_o == 1'b0, "R12", "valid after reset", 64'(msg_valid_o), 64'd0);
    check(tbl_idx_o == '0, "R12", "index after reset", 64'(tbl_idx_o), 64'd0);

    // R1 R3 R5: three edge pins rise together, ascending dispatch
    tbl[4]  = mk(8'h03, 1'b0, 3'd0, 8'h31, 1'b0, 1'b0, 1'b0);
    tbl[9]  = mk(8'hA5, 1'b1, 3'd1, 8'h52, 1'b1, 1'b0, 1'b0);
    tbl[17] = mk(8'h0F, 1'b0, 3'd4, 8'h9C, 1'b0, 1'b0, 1'b0);
    expect_msg(4, "R5");
    expect_msg(9, "R1");
    expect_msg(17, "R5");
    pin_i[17] = 1'b1; pin_i[9] = 1'b1; pin_i[4] = 1'b1;
    drain("R5");

    // R3 falling edge ignored
    pin_i[17] = 1'b0; pin_i[9] = 1'b0; pin_i[4] = 1'b0;
    drain("R3");
    // R7 edge pins were cleared by dispatch
    tbl_write_pulse();
    drain("R7");

    // R2 R7 level pin
    level_mode_i[7] = 1'b1;
    tbl[7] = mk(8'h11, 1'b0, 3'd0, 8'h47, 1'b0, 1'b1, 1'b0);
    tick(2);
    expect_msg(7, "R2");
    pin_i[7] = 1'b1;
    drain("R2");
    expect_msg(7, "R7");
    tbl_write_pulse();
    drain("R7");
    pin_i[7] = 1'b0;
    tick(5);
    tbl_write_pulse();
    drain("R2");

    // R4 pulse on level pin
    level_mode_i[8] = 1'b1;
    tbl[8] = mk(8'h22, 1'b1, 3'd0, 8'h58, 1'b1, 1'b1, 1'b0);
    tick(2);
    expect_msg(8, "R4");
    pulse_i[8] = 1'b1;
    tick(1);
    pulse_i[8] = 1'b0;
    drain("R4");
    tbl_write_pulse();
    drain("R4");

    // R9 unsupported delivery mode
    tbl[3] = mk(8'h44, 1'b0, 3'd7, 8'h40, 1'b0, 1'b0, 1'b0);
    expect_msg(3, "R9");
    pin_i[3] = 1'b1;
    drain("R9");
    pin_i[3] = 1'b0;

    // R6 masked pending pin survives, sent after unmask
    tbl[20] = mk(8'h55, 1'b0, 3'd2, 8'h6A, 1'b0, 1'b0, 1'b1);
    pin_i[20] = 1'b1;
    drain("R6");
    tbl[20] = mk(8'h55, 1'b0, 3'd2, 8'h6A, 1'b0, 1'b0, 1'b0);
    expect_msg(20, "R6");
    tbl_write_pulse();
    drain("R6");
    pin_i[20] = 1'b0;

    // R8 request behind the scan position triggers a second pass
    tbl[5] = mk(8'h66, 1'b0, 3'd0, 8'h75, 1'b0, 1'b0, 1'b0);
    tbl[2] = mk(8'h77, 1'b1, 3'd1, 8'h83, 1'b0, 1'b0, 1'b0);
    expect_msg(5, "R8");
    expect_msg(2, "R8");
    pin_i[5] = 1'b1;
    tick(15);
    pin_i[2] = 1'b1;
    drain("R8");
    pin_i[5] = 1'b0; pin_i[2] = 1'b0;
    tick(4);

    // R10 stall holds the message
    tbl[6] = mk(8'h88, 1'b0, 3'd5, 8'h91, 1'b1, 1'b0, 1'b0);
    msg_ready_i = 1'b0;
    expect_msg(6, "R10");
    pin_i[6] = 1'b1;
    tick(20);
    check(msg_valid_o == 1'b1, "R10", "valid during stall", 64'(msg_valid_o), 64'd1);
    check(msg_pin_o == 5'd6, "R10", "pin during stall", 64'(msg_pin_o), 64'd6);
    tick(10);
    check(msg_vector_o == 8'h91, "R10", "vector held", 64'(msg_vector_o), 64'h91);
    msg_ready_i = 1'b1;
    drain("R10");
    pin_i[6] = 1'b0;

    // R11 active-low edge pin: high-to-low is the request
    tbl[12] = mk(8'h99, 1'b0, 3'd0, 8'hA3, 1'b1, 1'b0, 1'b0);
    expect_msg(12, "R11");
    pin_i[12] = 1'b0;
    drain("R11");
    pin_i[12] = 1'b1;
    drain("R11");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule